// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a chain of 8-byte descriptors in memory and turns them into transfer requests for a separate data mover. It starts when a start pulse arrives while the protocol mode input selects the chained-descriptor mode. It then reads each descriptor through a request/response memory port and decodes the attribute bits. Depending on the action field, it skips the descriptor, hands an address and a length to the mover, or jumps to a new table address. The walk stops after the descriptor that carries the end flag. The block reports the result on plain single-cycle status pulses.

Each descriptor is one 64-bit little-endian word, laid out as follows:

- bits 15:0 are the attribute.
- bits 31:16 are the length.
- bits 63:32 are the address.

In the attribute, bit 0 marks the descriptor valid, bit 1 marks the end and bit 2 requests an interrupt. Bits 5:4 give the action: 0 is no-op, 1 is reserved, 2 is transfer and 3 is link.

Both streaming edges are valid/ready. The read request and the transfer request each stay asserted, with constant payload, until the partner raises ready. Only one of the two is ever pending. The read response has no ready: the walker accepts it whenever it is waiting for one.

Top module: `adma_walker`

## Requirements
- R1: A start pulse while idle with mode equal to 2 raises busy and issues a read request at the programmed base address.
- R2: A start pulse with mode other than 2 is ignored: no read request is issued and busy stays low.
- R3: A valid descriptor with action 2 issues one transfer request carrying bits 63:32 as its address and bits 31:16 as its byte length.
- R4: A length field of zero is issued as 65536 bytes.
- R5: A valid descriptor with action 0 or 1 issues no transfer, and the next fetch is at the descriptor's own address plus 8.
- R6: A valid descriptor with action 3 issues no transfer, and the next fetch is at its address field.
- R7: After the descriptor with the end bit (bit 1) completes, done pulses for exactly one cycle and busy falls. For a transfer, completion means the transfer handshake.
- R8: A fetched descriptor with bit 0 clear raises a one-cycle error pulse, issues no transfer and no done pulse, and returns the walker to idle.
- R9: A descriptor with bit 2 set produces one single-cycle irq pulse. For a transfer the pulse comes on the cycle after the transfer handshake; for a no-op or link it comes on the cycle after decode.
- R10: A pending request holds its valid and payload until ready is seen. A read request and a transfer request are never asserted together, so no fetch happens while a transfer waits.
- R11: After reset, busy, done, irq, error, the read request and the transfer request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| mode | input | 2 | Protocol mode; value 2 selects descriptor walking |
| base_addr | input | 32 | Address of the first descriptor |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 32 | Descriptor address to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Descriptor word, little-endian |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Data mover acknowledges the transfer |
| xfer_addr | output | 32 | Transfer address |
| xfer_len | output | 17 | Transfer length in bytes (1 to 65536) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle descriptor interrupt pulse |
| dma_err | output | 1 | One-cycle error pulse |

## Verification
The bench goes after these corner cases:

- **Zero length.** A design that passes the raw field through hands the mover a zero-byte transfer instead of 65536.
- **Link descriptor.** A design that steps past it, instead of jumping, fetches the wrong slot. The bench sees this in the address of the last fetch.
- **Invalid descriptor.** A design that ignores the valid bit issues a transfer, or reports done, where an error is due.
- **Reserved action and no-op.** A design that treats either as a transfer, or does not advance, shows a wrong transfer count or a hung walk.
- **Interrupt flag.** The bench counts irq pulses, so a design that drops the interrupt or repeats it is caught.
- **Mover back-pressure.** While the mover stalls, a design that fetches ahead raises both requests at once.
- **Wrong mode.** A design that ignores the mode starts a walk where none is due.

// File: rtl/adma_walk_pkg.sv
package adma_walk_pkg;
  localparam int ATTR_W = 16;
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_CHAIN = 2'd2;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'd0,
    ACT_RSVD = 2'd1,
    ACT_XFER = 2'd2,
    ACT_LINK = 2'd3
  } act_e;

  typedef struct packed {
    logic valid;
    logic last;
    logic intr;
    act_e act;
  } attr_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WAIT  = 2'd2,
    S_XFER  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/adma_desc_decode.sv
module adma_desc_decode
  import adma_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int WORD_W = ATTR_W + LEN_W + ADDR_W
) (
  input  logic [WORD_W-1:0] word,
  output attr_t             attr,
  output logic [LEN_W:0]    len_bytes,
  output logic [ADDR_W-1:0] addr
);
  logic [ATTR_W-1:0] raw_attr;
  logic [LEN_W-1:0]  raw_len;

  assign raw_attr = word[ATTR_W-1:0];
  assign raw_len  = word[ATTR_W +: LEN_W];
  assign addr     = word[ATTR_W+LEN_W +: ADDR_W];

  assign attr.valid = raw_attr[0];
  assign attr.last  = raw_attr[1];
  assign attr.intr  = raw_attr[2];
  assign attr.act   = act_e'(raw_attr[5:4]);

  // an all-zero length field stands for the full 2**LEN_W bytes
  assign len_bytes = (raw_len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, raw_len};
endmodule

// File: rtl/adma_desc_ptr.sv
module adma_desc_ptr #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + STEP_V;
  end
endmodule

// File: rtl/adma_walker.sv
module adma_walker
  import adma_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int WORD_W     = ATTR_W + LEN_W + ADDR_W,
  localparam int DESC_BYTES = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [LEN_W:0]    xfer_len,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              dma_err
);
  walk_st_e          st;
  attr_t             d_attr;
  logic [LEN_W:0]    d_len;
  logic [ADDR_W-1:0] d_addr;
  logic [ADDR_W-1:0] ptr;
  logic              ptr_load, ptr_step;
  logic [ADDR_W-1:0] ptr_val;
  logic              go, got, x_hs;
  logic              cur_last, cur_intr;

  adma_desc_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .word(rd_rsp_data), .attr(d_attr), .len_bytes(d_len), .addr(d_addr)
  );

  adma_desc_ptr #(.ADDR_W(ADDR_W), .STRIDE(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_val),
    .step(ptr_step), .ptr(ptr)
  );

  assign go   = (st == S_IDLE) && start && (mode == MODE_CHAIN);
  assign got  = (st == S_WAIT) && rd_rsp_valid;
  assign x_hs = (st == S_XFER) && xfer_ready;

  always_comb begin
    ptr_load = go || (got && d_attr.valid && d_attr.act == ACT_LINK);
    ptr_val  = go ? base_addr : d_addr;
    ptr_step = x_hs || (got && d_attr.valid &&
               (d_attr.act == ACT_NOP || d_attr.act == ACT_RSVD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      xfer_addr <= '0;
      xfer_len  <= '0;
      cur_last  <= 1'b0;
      cur_intr  <= 1'b0;
      done      <= 1'b0;
      irq       <= 1'b0;
      dma_err   <= 1'b0;
    end else begin
      done    <= 1'b0;
      irq     <= 1'b0;
      dma_err <= 1'b0;
      unique case (st)
        S_IDLE:  if (go) st <= S_FETCH;
        S_FETCH: if (rd_req_ready) st <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          if (!d_attr.valid) begin
            dma_err <= 1'b1;
            st      <= S_IDLE;
          end else if (d_attr.act == ACT_XFER) begin
            xfer_addr <= d_addr;
            xfer_len  <= d_len;
            cur_last  <= d_attr.last;
            cur_intr  <= d_attr.intr;
            st        <= S_XFER;
          end else begin
            irq  <= d_attr.intr;
            done <= d_attr.last;
            st   <= d_attr.last ? S_IDLE : S_FETCH;
          end
        end
        S_XFER: if (xfer_ready) begin
          irq  <= cur_intr;
          done <= cur_last;
          st   <= cur_last ? S_IDLE : S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == S_FETCH);
  assign rd_req_addr  = ptr;
  assign xfer_valid   = (st == S_XFER);
  assign busy         = (st != S_IDLE);
endmodule

// File: rtl/adma_walk_checks.sv
module adma_walk_checks #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        mode,
  input logic              busy,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [LEN_W:0]    xfer_len,
  input logic              done,
  input logic              irq,
  input logic              dma_err
);
  assert_xfer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_single_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && xfer_valid));

  assert_len_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_len != '0);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, dma_err}));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((xfer_valid && xfer_ready) || rd_rsp_valid));

  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && mode != 2'd2 |=> !busy);
endmodule

bind adma_walker adma_walk_checks #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
  .xfer_len(xfer_len), .done(done), .irq(irq), .dma_err(dma_err)
);

// File: tb/adma_walker_test.sv
module adma_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic [31:0] base_addr = '0;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [31:0] xfer_addr;
  logic [16:0] xfer_len;
  logic        busy, done, irq, dma_err;

  always #5 clk = ~clk;

  adma_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_addr(base_addr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .busy(busy), .done(done), .irq(irq), .dma_err(dma_err)
  );

  int checks = 0, failures = 0, cyc = 0;
  logic [63:0] mem [64];
  logic        rsp_pend = 1'b0;
  logic [63:0] rsp_q = '0;
  int stall_cfg = 0, stall_left = 0;
  int n_x = 0, n_irq = 0, n_done = 0, n_err = 0, n_rd = 0, n_overlap = 0;
  logic [31:0] last_rd = '0;
  logic [31:0] xa [4];
  logic [16:0] xl [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory and mover models plus monitors, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    rd_rsp_valid = rsp_pend;
    rd_rsp_data  = rsp_q;
    rsp_pend     = 1'b0;
    rd_req_ready = 1'b1;
    if (rd_req_valid && rd_req_ready) begin
      rsp_pend = 1'b1;
      rsp_q    = mem[rd_req_addr[8:3]];
      last_rd  = rd_req_addr;
      n_rd++;
    end
    if (xfer_valid) begin
      if (stall_left > 0) begin xfer_ready = 1'b0; stall_left--; end
      else xfer_ready = 1'b1;
    end else begin
      xfer_ready = 1'b0;
      stall_left = stall_cfg;
    end
    if (xfer_valid && xfer_ready) begin
      if (n_x < 4) begin xa[n_x] = xfer_addr; xl[n_x] = xfer_len; end
      n_x++;
    end
    if (rd_req_valid && xfer_valid) n_overlap++;
    if (irq) n_irq++;
    if (done) n_done++;
    if (dma_err) n_err++;
  end

  task automatic clear_counts();
    n_x = 0; n_irq = 0; n_done = 0; n_err = 0; n_rd = 0; n_overlap = 0;
  endtask

  task automatic run_walk(input logic [31:0] base);
    clear_counts();
    @(negedge clk);
    base_addr = base; mode = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (n_done != 0 || n_err != 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] attr;
    logic [15:0] len;
    logic [31:0] addr;
    logic [2:0]  nx;
    logic [16:0] xlen;
    logic        err;
    logic [1:0]  nirq;
    logic        dn;
    logic [31:0] last;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{16'h0023, 16'h0200, 32'h0000_1000, 3'd1, 17'h00200, 1'b0, 2'd0, 1'b1, 32'h00},
    '{16'h0025, 16'h0004, 32'h0000_2004, 3'd1, 17'h00004, 1'b0, 2'd1, 1'b1, 32'h08},
    '{16'h0023, 16'h0000, 32'h0000_3000, 3'd1, 17'h10000, 1'b0, 2'd0, 1'b1, 32'h00},
    '{16'h0001, 16'h0040, 32'h0000_4000, 3'd0, 17'h00000, 1'b0, 2'd0, 1'b1, 32'h08},
    '{16'h0031, 16'h0000, 32'h0000_0040, 3'd0, 17'h00000, 1'b0, 2'd0, 1'b1, 32'h40},
    '{16'h0022, 16'h0010, 32'h0000_5000, 3'd0, 17'h00000, 1'b1, 2'd0, 1'b0, 32'h00},
    '{16'h0011, 16'h0010, 32'h0000_6000, 3'd0, 17'h00000, 1'b0, 2'd0, 1'b1, 32'h08},
    '{16'h0007, 16'h0000, 32'h0000_0000, 3'd0, 17'h00000, 1'b0, 2'd1, 1'b1, 32'h00}
  };

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 outputs", {26'd0, done, irq, dma_err, rd_req_valid, xfer_valid, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: wrong mode ignored
    clear_counts();
    mode = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 no fetch", n_rd, 0);
    chk("R2 busy low", {31'd0, busy}, 32'd0);

    // table of single-descriptor cases (R3 R4 R5 R6 R7 R8 R9)
    for (int v = 0; v < NV; v++) begin
      mem[0] = {VEC[v].addr, VEC[v].len, VEC[v].attr};
      mem[1] = 64'h3;
      mem[8] = 64'h3;
      run_walk(32'h0);
      chk($sformatf("R3 R5 R6 xfers v%0d", v), n_x, VEC[v].nx);
      if (VEC[v].nx != 0) begin
        chk($sformatf("R3 addr v%0d", v), xa[0], VEC[v].addr);
        chk($sformatf("R4 len v%0d", v), {15'd0, xl[0]}, {15'd0, VEC[v].xlen});
      end
      chk($sformatf("R8 err v%0d", v), n_err, VEC[v].err);
      chk($sformatf("R9 irq v%0d", v), n_irq, VEC[v].nirq);
      chk($sformatf("R7 done v%0d", v), n_done, VEC[v].dn);
      chk($sformatf("R5 R6 last fetch v%0d", v), last_rd, VEC[v].last);
      chk($sformatf("R7 idle v%0d", v), {31'd0, busy}, 32'd0);
    end

    // R1 R5 R6: chain at a nonzero base with a link in the middle
    mem[32] = {32'h0000_A000, 16'h0010, 16'h0021};
    mem[33] = {32'h0, 16'h0, 16'h0001};
    mem[34] = {32'h0000_0180, 16'h0, 16'h0031};
    mem[48] = {32'h0000_B000, 16'h0020, 16'h0027};
    clear_counts();
    @(negedge clk);
    base_addr = 32'h100; mode = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy", {31'd0, busy}, 32'd1);
    chk("R1 fetch addr", rd_req_addr, 32'h100);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (n_done != 0) break;
    end
    repeat (4) @(negedge clk);
    chk("R6 chain xfers", n_x, 2);
    chk("R3 chain addr0", xa[0], 32'hA000);
    chk("R3 chain addr1", xa[1], 32'hB000);
    chk("R3 chain len1", {15'd0, xl[1]}, 32'h20);
    chk("R6 chain last fetch", last_rd, 32'h180);
    chk("R9 chain irq", n_irq, 1);
    chk("R7 chain done", n_done, 1);

    // R10: mover back-pressure
    stall_cfg = 6;
    mem[0] = {32'h0000_7000, 16'h0008, 16'h0021};
    mem[1] = {32'h0000_7100, 16'h0008, 16'h0023};
    run_walk(32'h0);
    chk("R10 xfers under stall", n_x, 2);
    chk("R10 no overlap", n_overlap, 0);
    chk("R10 second addr", xa[1], 32'h7100);
    stall_cfg = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule